// File: doc/BRIEF.md
# Slave Security Firewall Filter

This block stands between one request/response channel of an on-chip interconnect and a group of slaves that share an address window. Each request carries an address, a read/write flag, a secure/nonsecure attribute, a privileged/user attribute and write data. The filter checks every accepted request against a set of security control registers. A request that passes goes on to the slave that its address selects. A request that fails never reaches any slave. Instead the filter completes it locally with an ordinary response. A blocked read returns filler data, and a blocked write is discarded.

Each slave has one security bit, and every bit is secure after reset. One slave, the memory slave, also holds a table of 4 KB-aligned regions. Each region sets the security of its own page range. The lowest-numbered enabled region that matches takes effect. An address that lies outside every region falls back to the memory slave's own bit. A fixed subset of slaves also sits behind a privilege filter, and that filter judges writes only. The control registers change only through secure writes on a dedicated configuration port. A nonsecure configuration write is dropped.

The filter handles one transaction at a time. It uses a four-state machine:
- `S_IDLE`: waits for a request and accepts it.
- `S_FWD`: holds the request to the slave until the slave reports completion.
- `S_RESP`: returns the slave's data for one cycle.
- `S_DENY`: returns the local completion for one cycle.

The transitions are:
- IDLE→FWD when the accepted request passes.
- IDLE→DENY when it fails.
- FWD→RESP on slave completion.
- RESP→IDLE and DENY→IDLE unconditionally.

Top module: `fw_sec_filter`

## Requirements
- R1: After reset every slave security bit is 1 (secure) and every region is disabled, so a nonsecure read to any of the four slaves is blocked.
- R2: A secure request to a secure slave that is not privilege-blocked is presented on `slv_valid` with the request's address, direction and write data held stable until `slv_done`. The slave's read data is returned on `rsp_rdata` in the response cycle.
- R3: A nonsecure request whose effective target is secure never raises `slv_valid`. It completes with `rsp_valid` one cycle after acceptance, and a blocked read returns a 16-bit LFSR value replicated across the data width, so bits [31:16] equal bits [15:0].
- R4: Configuration writes take effect only when `cfg_secure` is 1, and a write with `cfg_secure` 0 changes nothing. Index 0 holds the slave security bits, with bit k for slave k and 1 meaning secure. Index 2i+1 holds the base page of region i in bits [19:0]. Index 2i+2 holds the enable of region i in bit 31, its security (1 = secure) in bit 30, and its limit page in bits [19:0].
- R5: A slave whose security bit is 0 forwards nonsecure requests.
- R6: Slaves in `PRIV_MASK` (slave 3 by default) block writes with `req_priv` 0 even when they are secure. Reads to them are never privilege-checked.
- R7: For the memory slave (slave 0, selected by address bits [21:20]), an enabled region i matches when base ≤ addr[31:12] ≤ limit. The lowest-numbered matching region sets the security of the access.
- R8: A memory-slave address that matches no enabled region uses slave 0's security bit.
- R9: `req_ready` is low from the cycle after acceptance until the response has completed. `rsp_valid` lasts exactly one cycle, and `req_ready` returns in the cycle after it.
- R10: A blocked write is dropped: the slave sees no request, and the master still receives a normal one-cycle completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure transaction |
| req_priv | input | 1 | 1 = privileged transaction |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Completion, one cycle |
| rsp_rdata | output | DATA_W | Read data or filler |
| slv_valid | output | 1 | Request to slave group |
| slv_addr | output | ADDR_W | Forwarded address |
| slv_write | output | 1 | Forwarded direction |
| slv_wdata | output | DATA_W | Forwarded write data |
| slv_done | input | 1 | Slave completes the forwarded request |
| slv_rdata | input | DATA_W | Slave read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_secure | input | 1 | Security attribute of the configuration write |
| cfg_idx | input | CFG_IW | Configuration register index |
| cfg_wdata | input | DATA_W | Configuration write data |

## Verification
Some properties are checked on every cycle:
- A nonsecure request whose effective target is secure never reaches the slave side, and neither does an unprivileged write to a privilege-filtered slave.
- A secure request that is not privilege-blocked always does reach the slave.
- A nonsecure configuration write leaves the slave security bits unchanged.
- The forwarded request stays stable until the slave completes it, and the busy/response timing holds.

Other behaviour only the directed scenarios can show:
- How overlapping regions resolve by priority, and how out-of-region addresses fall back to the slave's own bit.
- The replicated filler pattern on blocked reads.
- That changes to the registers actually alter later decisions at the ports.

// File: rtl/fw_pkg.sv
package fw_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FWD,
        S_RESP,
        S_DENY
    } fw_state_t;

    localparam logic [15:0] FILL_SEED = 16'hACE1;
    localparam logic [15:0] FILL_TAPS = 16'hB400;

endpackage

// File: rtl/fw_cfg_regs.sv
module fw_cfg_regs #(
    parameter int NSLV   = 4,
    parameter int NREG   = 6,
    parameter int PG_W   = 20,
    parameter int DATA_W = 32,
    parameter int CFG_IW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic                       cfg_secure,
    input  logic [CFG_IW-1:0]          cfg_idx,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [NSLV-1:0]            slv_sec,
    output logic [NREG-1:0][PG_W-1:0]  rg_base,
    output logic [NREG-1:0][PG_W-1:0]  rg_limit,
    output logic [NREG-1:0]            rg_en,
    output logic [NREG-1:0]            rg_sec
);

    localparam int EN_BIT  = DATA_W - 1;
    localparam int SEC_BIT = DATA_W - 2;

    logic wr_ok;
    logic unused_wdata;

    assign wr_ok        = cfg_we && cfg_secure;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_sec <= '1;
        end else if (wr_ok && cfg_idx == '0) begin
            slv_sec <= cfg_wdata[NSLV-1:0];
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_region
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rg_base[i]  <= '0;
                rg_limit[i] <= '0;
                rg_en[i]    <= 1'b0;
                rg_sec[i]   <= 1'b1;
            end else if (wr_ok) begin
                if (cfg_idx == CFG_IW'(2*i + 1)) begin
                    rg_base[i] <= cfg_wdata[PG_W-1:0];
                end
                if (cfg_idx == CFG_IW'(2*i + 2)) begin
                    rg_limit[i] <= cfg_wdata[PG_W-1:0];
                    rg_en[i]    <= cfg_wdata[EN_BIT];
                    rg_sec[i]   <= cfg_wdata[SEC_BIT];
                end
            end
        end
    end

endmodule

// File: rtl/fw_region_match.sv
module fw_region_match #(
    parameter int NREG = 6,
    parameter int PG_W = 20
) (
    input  logic [PG_W-1:0]            page,
    input  logic [NREG-1:0][PG_W-1:0]  rg_base,
    input  logic [NREG-1:0][PG_W-1:0]  rg_limit,
    input  logic [NREG-1:0]            rg_en,
    input  logic [NREG-1:0]            rg_sec,
    output logic                       hit,
    output logic                       hit_sec
);

    logic [NREG-1:0] in_range;

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign in_range[i] = rg_en[i]
                           && (page >= rg_base[i])
                           && (page <= rg_limit[i]);
    end

    // Walk from the highest index down so the lowest matching index is left last.
    always_comb begin
        hit     = 1'b0;
        hit_sec = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                hit     = 1'b1;
                hit_sec = rg_sec[i];
            end
        end
    end

endmodule

// File: rtl/fw_fill_lfsr.sv
module fw_fill_lfsr
    import fw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] fill
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= FILL_SEED;
        end else begin
            fill <= {1'b0, fill[15:1]} ^ (fill[0] ? FILL_TAPS : 16'h0000);
        end
    end

endmodule

// File: rtl/fw_sec_filter.sv
module fw_sec_filter
    import fw_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter int              NSLV      = 4,
    parameter int              SLV_AW    = 20,
    parameter int              NREG      = 6,
    parameter int              MEM_SLV   = 0,
    parameter logic [NSLV-1:0] PRIV_MASK = 4'b1000,
    parameter int              CFG_IW    = $clog2(2*NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              slv_valid,
    output logic [ADDR_W-1:0] slv_addr,
    output logic              slv_write,
    output logic [DATA_W-1:0] slv_wdata,
    input  logic              slv_done,
    input  logic [DATA_W-1:0] slv_rdata,
    input  logic              cfg_we,
    input  logic              cfg_secure,
    input  logic [CFG_IW-1:0] cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata
);

    localparam int SEL_W = $clog2(NSLV);
    localparam int PG_W  = ADDR_W - 12;
    localparam int REP   = DATA_W / 16;

    fw_state_t state, state_nx;

    logic [SEL_W-1:0]           sel;
    logic [PG_W-1:0]            page;
    logic [NSLV-1:0]            slv_sec;
    logic [NREG-1:0][PG_W-1:0]  rg_base;
    logic [NREG-1:0][PG_W-1:0]  rg_limit;
    logic [NREG-1:0]            rg_en;
    logic [NREG-1:0]            rg_sec;
    logic                       hit, hit_sec;
    logic                       eff_secure, sec_ok, priv_ok, pass, accept;
    logic [15:0]                fill;
    logic [DATA_W-1:0]          cap_rdata;
    logic [ADDR_W-1:0]          lat_addr;
    logic                       lat_write;
    logic [DATA_W-1:0]          lat_wdata;

    fw_cfg_regs #(
        .NSLV(NSLV), .NREG(NREG), .PG_W(PG_W), .DATA_W(DATA_W), .CFG_IW(CFG_IW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_secure(cfg_secure),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .slv_sec(slv_sec), .rg_base(rg_base), .rg_limit(rg_limit),
        .rg_en(rg_en), .rg_sec(rg_sec)
    );

    fw_region_match #(.NREG(NREG), .PG_W(PG_W)) u_match (
        .page(page), .rg_base(rg_base), .rg_limit(rg_limit),
        .rg_en(rg_en), .rg_sec(rg_sec),
        .hit(hit), .hit_sec(hit_sec)
    );

    fw_fill_lfsr u_fill (.clk(clk), .rst_n(rst_n), .fill(fill));

    // Access decision
    assign sel        = req_addr[SLV_AW +: SEL_W];
    assign page       = req_addr[ADDR_W-1:12];
    assign eff_secure = (sel == SEL_W'(MEM_SLV) && hit) ? hit_sec : slv_sec[sel];
    assign sec_ok     = req_secure || !eff_secure;
    assign priv_ok    = !req_write || req_priv || !PRIV_MASK[sel];
    assign pass       = sec_ok && priv_ok;
    assign accept     = req_valid && (state == S_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = pass ? S_FWD : S_DENY;
            S_FWD:   if (slv_done)  state_nx = S_RESP;
            S_RESP:  state_nx = S_IDLE;
            S_DENY:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Request capture and slave data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            cap_rdata <= '0;
        end else begin
            if (accept) begin
                lat_addr  <= req_addr;
                lat_write <= req_write;
                lat_wdata <= req_wdata;
            end
            if (state == S_FWD && slv_done) begin
                cap_rdata <= slv_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        slv_valid = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_FWD:  slv_valid = 1'b1;
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = cap_rdata;
            end
            S_DENY: begin
                rsp_valid = 1'b1;
                rsp_rdata = {REP{fill}};
            end
            default: ;
        endcase
    end

    assign slv_addr  = lat_addr;
    assign slv_write = lat_write;
    assign slv_wdata = lat_wdata;

endmodule

// File: rtl/fw_sec_filter_chk.sv
module fw_sec_filter_chk #(
    parameter int              ADDR_W    = 32,
    parameter int              NSLV      = 4,
    parameter int              SLV_AW    = 20,
    parameter logic [NSLV-1:0] PRIV_MASK = 4'b1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_secure,
    input logic              req_priv,
    input logic              rsp_valid,
    input logic              slv_valid,
    input logic              slv_done,
    input logic [ADDR_W-1:0] slv_addr,
    input logic              cfg_we,
    input logic              cfg_secure,
    input logic              eff_secure,
    input logic [NSLV-1:0]   slv_sec
);

    localparam int SEL_W = $clog2(NSLV);

    logic [SEL_W-1:0] c_sel;
    logic             c_acc;
    logic             c_priv_blk;

    assign c_sel      = req_addr[SLV_AW +: SEL_W];
    assign c_acc      = req_valid && req_ready;
    assign c_priv_blk = req_write && !req_priv && PRIV_MASK[c_sel];

    // R3
    deny_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_acc && !req_secure && eff_secure) |=> (!slv_valid && rsp_valid));

    // R6
    priv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_acc && c_priv_blk) |=> (!slv_valid && rsp_valid));

    // R2
    secure_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_acc && req_secure && !c_priv_blk) |=> slv_valid);

    // R2
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_valid && !slv_done) |=> (slv_valid && $stable(slv_addr)));

    // R4
    cfg_ns_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_secure) |=> $stable(slv_sec));

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc |=> !req_ready);

    // R9
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

bind fw_sec_filter fw_sec_filter_chk #(
    .ADDR_W(ADDR_W), .NSLV(NSLV), .SLV_AW(SLV_AW), .PRIV_MASK(PRIV_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_secure(req_secure), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .slv_valid(slv_valid), .slv_done(slv_done),
    .slv_addr(slv_addr), .cfg_we(cfg_we), .cfg_secure(cfg_secure),
    .eff_secure(eff_secure), .slv_sec(slv_sec)
);

// File: tb/test_fw_sec_filter.sv
module test_fw_sec_filter;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CFG_IW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_secure = 1'b0;
    logic              req_priv = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              slv_valid;
    logic [ADDR_W-1:0] slv_addr;
    logic              slv_write;
    logic [DATA_W-1:0] slv_wdata;
    logic              slv_done = 1'b0;
    logic [DATA_W-1:0] slv_rdata = '0;
    logic              cfg_we = 1'b0;
    logic              cfg_secure = 1'b0;
    logic [CFG_IW-1:0] cfg_idx = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fw_sec_filter i_fw_sec_filter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_secure(req_secure), .req_priv(req_priv),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .slv_valid(slv_valid), .slv_addr(slv_addr), .slv_write(slv_write),
        .slv_wdata(slv_wdata), .slv_done(slv_done), .slv_rdata(slv_rdata),
        .cfg_we(cfg_we), .cfg_secure(cfg_secure), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata)
    );

    // Slave model: completes one cycle after seeing a request
    always @(negedge clk) begin
        slv_done  <= slv_valid;
        slv_rdata <= {~slv_addr[15:0], slv_addr[15:0]};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input bit sec, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_secure = sec; cfg_idx = CFG_IW'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_secure = 1'b0;
    endtask

    // Runs one transaction; reports whether it reached the slave and the response data
    task automatic txn(input logic [31:0] a, input bit wr, input bit sec, input bit prv,
                       input logic [31:0] wd, output logic [31:0] rd, output bit fwd,
                       output logic [31:0] seen_wd);
        int cyc = 0;
        fwd = 1'b0; seen_wd = '0; rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_secure = sec;
        req_priv = prv; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "ready low after accept", 32'(req_ready), 32'd0);
        while (!rsp_valid && cyc < 50) begin
            if (slv_valid) begin
                fwd = 1'b1;
                seen_wd = slv_wdata;
                check(slv_addr == a && slv_write == wr, "R2", "forwarded addr",
                      slv_addr, a);
            end
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata;
        check(rsp_valid == 1'b1, "R9", "response seen", 32'(rsp_valid), 32'd1);
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "single response cycle",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] slave_data(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic expect_blocked_read(input logic [31:0] a, input bit sec, input string req);
        logic [31:0] rd, wdv; bit fwd;
        txn(a, 1'b0, sec, 1'b0, '0, rd, fwd, wdv);
        check(!fwd, req, "blocked read reached slave", 32'(fwd), 32'd0);
        check(rd[31:16] == rd[15:0], "R3", "filler replicated", rd, {rd[15:0], rd[15:0]});
    endtask

    task automatic expect_fwd_read(input logic [31:0] a, input bit sec, input bit prv,
                                   input string req);
        logic [31:0] rd, wdv; bit fwd;
        txn(a, 1'b0, sec, prv, '0, rd, fwd, wdv);
        check(fwd, req, "read not forwarded", 32'(fwd), 32'd1);
        check(rd == slave_data(a), req, "read data", rd, slave_data(a));
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && slv_valid == 1'b0, "R1",
              "idle outputs after reset", {29'd0, req_ready, rsp_valid, slv_valid}, 32'd4);
        for (int k = 0; k < 4; k++) expect_blocked_read(32'(k) << 20, 1'b0, "R1");
    endtask

    task automatic t_secure_access();
        logic [31:0] rd, wdv; bit fwd;
        expect_fwd_read(32'h0010_0040, 1'b1, 1'b0, "R2");
        txn(32'h0020_0010, 1'b1, 1'b1, 1'b0, 32'hCAFE_0123, rd, fwd, wdv);
        check(fwd && wdv == 32'hCAFE_0123, "R2", "secure write data", wdv, 32'hCAFE_0123);
        // R10: nonsecure write to secure slave dropped
        txn(32'h0020_0010, 1'b1, 1'b0, 1'b1, 32'h1111_2222, rd, fwd, wdv);
        check(!fwd, "R10", "blocked write reached slave", 32'(fwd), 32'd0);
    endtask

    task automatic t_cfg();
        cfg_wr(1'b0, 0, 32'h0000_0000);
        expect_blocked_read(32'h0010_0000, 1'b0, "R4");
        cfg_wr(1'b1, 0, 32'h0000_000D);
        expect_fwd_read(32'h0010_0080, 1'b0, 1'b0, "R5");
        expect_blocked_read(32'h0020_0000, 1'b0, "R4");
    endtask

    task automatic t_priv();
        logic [31:0] rd, wdv; bit fwd;
        txn(32'h0030_0004, 1'b1, 1'b1, 1'b0, 32'hDEAD_0001, rd, fwd, wdv);
        check(!fwd, "R6", "user write to filtered slave", 32'(fwd), 32'd0);
        txn(32'h0030_0004, 1'b1, 1'b1, 1'b1, 32'hBEEF_0002, rd, fwd, wdv);
        check(fwd && wdv == 32'hBEEF_0002, "R6", "privileged write", wdv, 32'hBEEF_0002);
        expect_fwd_read(32'h0030_0008, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_regions();
        cfg_wr(1'b1, 1, 32'h0000_0004);
        cfg_wr(1'b1, 2, 32'hC000_0007);
        cfg_wr(1'b1, 3, 32'h0000_0002);
        cfg_wr(1'b1, 4, 32'h8000_0009);
        expect_blocked_read(32'h0000_5000, 1'b0, "R7");
        expect_fwd_read(32'h0000_8000, 1'b0, 1'b0, "R7");
        expect_fwd_read(32'h0000_2004, 1'b0, 1'b0, "R7");
        expect_blocked_read(32'h0002_0000, 1'b0, "R8");
        cfg_wr(1'b1, 0, 32'h0000_000C);
        expect_fwd_read(32'h0002_0000, 1'b0, 1'b0, "R8");
        expect_blocked_read(32'h0000_6000, 1'b0, "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_secure_access();
        t_cfg();
        t_priv();
        t_regions();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule